// File: doc/BRIEF.md
# Three-Format Instruction Decoder

This block turns a 32-bit instruction word into the control fields that a small load/store processor needs on its way to execution. It is purely combinational. The six bits at the top of the word select the instruction shape: register-to-register, register-with-immediate, or PC-relative jump. In register shape the low six bits choose the operation. The decoder extracts the register indices and builds a 32-bit operand from the immediate field, applying the extension rule that the operation requires. It also reports the ALU operation, whether a register is written and which one, memory read and write strobes, the kind of control transfer, and whether the link register receives the return address.

Words that match no known operation raise an illegal flag, and every side-effect strobe is held low for them. The register file, the ALU, the PC logic and the memory bus sit outside this block. A write aimed at register index 0 is passed through unchanged, because the register file discards it.

Top module: `instrDecoder`

## Requirements
- R1: `fmtKind` is 0 (register) when bits 31:26 are 0, 2 (jump) when they are 2 or 3, and 1 (immediate) for any other value.
- R2: For every word, `srcA` equals bits 25:21 and `srcB` equals bits 20:16.
- R3: With bits 31:26 equal to 0, the function code in bits 5:0 selects `aluOp` as follows: 0x20→0 add, 0x22→1 sub, 0x24→2 and, 0x25→3 or, 0x26→4 xor, 0x28→5 eq, 0x29→6 ne, 0x2a→7 lt, 0x2c→8 le, 0x04→9 sll, 0x06→10 srl, 0x07→11 sra. These operations set `regWrEn`=1, `dstIdx`=bits 15:11, `aluUseImm`=0 and `immValue`=0. Bits 10:6 have no effect on any output.
- R4: Main opcodes 0x08, 0x0a, 0x0c, 0x0d, 0x0e, 0x14, 0x16, 0x17, 0x18, 0x19, 0x1a and 0x1c select `aluOp` 0, 1, 2, 3, 4, 9, 10, 11, 5, 6, 7 and 8 respectively. They set `regWrEn`=1, `aluUseImm`=1 and `dstIdx`=bits 20:16.
- R5: For the arithmetic, compare, shift, branch and memory immediate opcodes, `immValue` is bits 15:0 sign-extended to 32 bits.
- R6: For opcodes 0x0c, 0x0d and 0x0e, `immValue` is bits 15:0 zero-extended.
- R7: Opcode 0x0f gives `immValue` = bits 15:0 shifted left by 16, with `aluOp`=12 (pass operand B), `aluUseImm`=1, `regWrEn`=1 and `dstIdx`=bits 20:16.
- R8: Opcodes 0x02 and 0x03 give `immValue` = bits 25:0 sign-extended, with `branchKind`=3 (relative jump). Opcode 0x02 writes no register.
- R9: Opcodes 0x03 and 0x13 set `linkSel`=1, `regWrEn`=1 and `dstIdx`=31, whatever the destination field holds.
- R10: Opcode 0x04 gives `branchKind`=1 (taken if zero) and 0x05 gives 2 (taken if non-zero), both without a register write. Opcodes 0x12 and 0x13 give `branchKind`=4 (jump to register). Opcode 0x12 writes no register.
- R11: Opcode 0x23 sets `memRead`=1, `regWrEn`=1 and `dstIdx`=bits 20:16. Opcode 0x2b sets `memWrite`=1 and `regWrEn`=0. Both use `aluOp`=0 with `aluUseImm`=1.
- R12: Any main opcode or function code not listed above sets `illegal`=1, with `regWrEn`, `memRead`, `memWrite` and `linkSel` at 0 and `branchKind` at 0. The all-zero word is illegal.
- R13: A legal register write to index 0 keeps `regWrEn`=1 with `dstIdx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word to decode |
| fmtKind | output | 2 | 0 register, 1 immediate, 2 jump |
| srcA | output | 5 | First source register index |
| srcB | output | 5 | Second source or store-data register index |
| dstIdx | output | 5 | Destination register index |
| regWrEn | output | 1 | Register write enable |
| immValue | output | 32 | Extended immediate operand |
| aluOp | output | 4 | ALU operation code |
| aluUseImm | output | 1 | ALU operand B comes from immValue |
| memRead | output | 1 | Load strobe |
| memWrite | output | 1 | Store strobe |
| branchKind | output | 3 | 0 none, 1 if-zero, 2 if-non-zero, 3 relative jump, 4 register jump |
| linkSel | output | 1 | Write return address to the link register |
| illegal | output | 1 | Unrecognised encoding |

## Verification
The embedded checks are evaluated only when the instruction word carries no unknown bits. They assume the word holds steady long enough for the combinational outputs to settle. The bench keeps to these limits: it drives fully known words, changes them only just after a rising clock edge, and samples the outputs half a period later. That leaves every decode path settled before any value is compared.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int WORD_W  = 32;
  localparam int OPC_W   = 6;
  localparam int REGI_W  = 5;
  localparam int IMM_W   = 16;
  localparam int JOFF_W  = 26;

  typedef enum logic [1:0] {FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_JMP = 2'd2} fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_EQ = 4'd5, ALU_NE = 4'd6, ALU_LT = 4'd7,
    ALU_LE = 4'd8, ALU_SLL = 4'd9, ALU_SRL = 4'd10, ALU_SRA = 4'd11,
    ALU_PASSB = 4'd12
  } alu_e;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0, BR_IFZERO = 3'd1, BR_IFNZ = 3'd2, BR_REL = 3'd3, BR_REG = 3'd4
  } br_e;

  typedef enum logic [2:0] {
    IMM_NONE = 3'd0, IMM_SX16 = 3'd1, IMM_ZX16 = 3'd2, IMM_HI16 = 3'd3, IMM_SX26 = 3'd4
  } imm_e;

  // strobes from control to the field datapath
  typedef struct packed {
    fmt_e fmt;
    imm_e immKind;
    logic link;
    logic dstFromRd;
  } fieldSel_t;

  // strobes from control straight to the top ports
  typedef struct packed {
    alu_e aluOp;
    logic useImm;
    logic regWr;
    logic memRd;
    logic memWr;
    br_e  branch;
    logic illegal;
  } ctrl_t;

  // main opcode values
  localparam logic [OPC_W-1:0] MO_REGFMT = 6'h00, MO_JREL = 6'h02, MO_JRELLNK = 6'h03,
    MO_BRZ = 6'h04, MO_BRNZ = 6'h05, MO_ADDK = 6'h08, MO_SUBK = 6'h0a, MO_ANDK = 6'h0c,
    MO_ORK = 6'h0d, MO_XORK = 6'h0e, MO_HIGHK = 6'h0f, MO_JREG = 6'h12, MO_JREGLNK = 6'h13,
    MO_SLLK = 6'h14, MO_SRLK = 6'h16, MO_SRAK = 6'h17, MO_EQK = 6'h18, MO_NEK = 6'h19,
    MO_LTK = 6'h1a, MO_LEK = 6'h1c, MO_LOAD = 6'h23, MO_STORE = 6'h2b;

  // function code values in register format
  localparam logic [OPC_W-1:0] FN_SLL = 6'h04, FN_SRL = 6'h06, FN_SRA = 6'h07,
    FN_ADD = 6'h20, FN_SUB = 6'h22, FN_AND = 6'h24, FN_OR = 6'h25, FN_XOR = 6'h26,
    FN_EQ = 6'h28, FN_NE = 6'h29, FN_LT = 6'h2a, FN_LE = 6'h2c;
endpackage

// File: rtl/decCtrl.sv
module decCtrl
  import instr_dec_pkg::*;
(
  input  logic [OPC_W-1:0] mainOp,
  input  logic [OPC_W-1:0] funcCode,
  output fieldSel_t        sel,
  output ctrl_t            ctrl
);
  always_comb begin
    sel  = '{fmt: FMT_IMM, immKind: IMM_SX16, link: 1'b0, dstFromRd: 1'b0};
    ctrl = '{aluOp: ALU_ADD, useImm: 1'b0, regWr: 1'b0, memRd: 1'b0,
             memWr: 1'b0, branch: BR_NONE, illegal: 1'b0};
    unique case (mainOp)
      MO_REGFMT: begin
        sel.fmt       = FMT_REG;
        sel.immKind   = IMM_NONE;
        sel.dstFromRd = 1'b1;
        ctrl.regWr    = 1'b1;
        unique case (funcCode)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_XOR:  ctrl.aluOp = ALU_XOR;
          FN_EQ:   ctrl.aluOp = ALU_EQ;
          FN_NE:   ctrl.aluOp = ALU_NE;
          FN_LT:   ctrl.aluOp = ALU_LT;
          FN_LE:   ctrl.aluOp = ALU_LE;
          FN_SLL:  ctrl.aluOp = ALU_SLL;
          FN_SRL:  ctrl.aluOp = ALU_SRL;
          FN_SRA:  ctrl.aluOp = ALU_SRA;
          default: begin
            ctrl.illegal = 1'b1;
            ctrl.regWr   = 1'b0;
          end
        endcase
      end
      MO_JREL, MO_JRELLNK: begin
        sel.fmt     = FMT_JMP;
        sel.immKind = IMM_SX26;
        ctrl.branch = BR_REL;
        sel.link    = (mainOp == MO_JRELLNK);
        ctrl.regWr  = (mainOp == MO_JRELLNK);
      end
      MO_BRZ:  ctrl.branch = BR_IFZERO;
      MO_BRNZ: ctrl.branch = BR_IFNZ;
      MO_JREG, MO_JREGLNK: begin
        ctrl.branch = BR_REG;
        sel.link    = (mainOp == MO_JREGLNK);
        ctrl.regWr  = (mainOp == MO_JREGLNK);
      end
      MO_ADDK, MO_SUBK, MO_SLLK, MO_SRLK, MO_SRAK,
      MO_EQK, MO_NEK, MO_LTK, MO_LEK: begin
        ctrl.useImm = 1'b1;
        ctrl.regWr  = 1'b1;
        unique case (mainOp)
          MO_SUBK: ctrl.aluOp = ALU_SUB;
          MO_SLLK: ctrl.aluOp = ALU_SLL;
          MO_SRLK: ctrl.aluOp = ALU_SRL;
          MO_SRAK: ctrl.aluOp = ALU_SRA;
          MO_EQK:  ctrl.aluOp = ALU_EQ;
          MO_NEK:  ctrl.aluOp = ALU_NE;
          MO_LTK:  ctrl.aluOp = ALU_LT;
          MO_LEK:  ctrl.aluOp = ALU_LE;
          default: ctrl.aluOp = ALU_ADD;
        endcase
      end
      MO_ANDK, MO_ORK, MO_XORK: begin
        sel.immKind = IMM_ZX16;
        ctrl.useImm = 1'b1;
        ctrl.regWr  = 1'b1;
        ctrl.aluOp  = (mainOp == MO_ANDK) ? ALU_AND :
                      (mainOp == MO_ORK)  ? ALU_OR  : ALU_XOR;
      end
      MO_HIGHK: begin
        sel.immKind = IMM_HI16;
        ctrl.aluOp  = ALU_PASSB;
        ctrl.useImm = 1'b1;
        ctrl.regWr  = 1'b1;
      end
      MO_LOAD: begin
        ctrl.useImm = 1'b1;
        ctrl.regWr  = 1'b1;
        ctrl.memRd  = 1'b1;
      end
      MO_STORE: begin
        ctrl.useImm = 1'b1;
        ctrl.memWr  = 1'b1;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/decFields.sv
module decFields
  import instr_dec_pkg::*;
#(
  parameter int LINK_IDX = 31
) (
  input  logic [JOFF_W-1:0]  body,
  input  fieldSel_t          sel,
  output logic [REGI_W-1:0]  srcA,
  output logic [REGI_W-1:0]  srcB,
  output logic [REGI_W-1:0]  dstIdx,
  output logic [WORD_W-1:0]  immValue
);
  localparam int RS1_LO = JOFF_W - REGI_W;
  localparam int RS2_LO = RS1_LO - REGI_W;
  localparam int RD_LO  = RS2_LO - REGI_W;

  logic [IMM_W-1:0] immRaw;
  assign immRaw = body[IMM_W-1:0];
  assign srcA   = body[JOFF_W-1:RS1_LO];
  assign srcB   = body[RS1_LO-1:RS2_LO];

  always_comb begin
    if (sel.link)            dstIdx = REGI_W'(LINK_IDX);
    else if (sel.dstFromRd)  dstIdx = body[RS2_LO-1:RD_LO];
    else if (sel.fmt == FMT_IMM) dstIdx = body[RS1_LO-1:RS2_LO];
    else                     dstIdx = '0;
  end

  always_comb begin
    unique case (sel.immKind)
      IMM_SX16: immValue = {{(WORD_W-IMM_W){immRaw[IMM_W-1]}}, immRaw};
      IMM_ZX16: immValue = {{(WORD_W-IMM_W){1'b0}}, immRaw};
      IMM_HI16: immValue = {immRaw, {(WORD_W-IMM_W){1'b0}}};
      IMM_SX26: immValue = {{(WORD_W-JOFF_W){body[JOFF_W-1]}}, body};
      default:  immValue = '0;
    endcase
  end
endmodule

// File: rtl/instrDecoder.sv
module instrDecoder
  import instr_dec_pkg::*;
#(
  parameter int LINK_IDX = 31
) (
  input  logic [31:0] instrWord,
  output logic [1:0]  fmtKind,
  output logic [4:0]  srcA,
  output logic [4:0]  srcB,
  output logic [4:0]  dstIdx,
  output logic        regWrEn,
  output logic [31:0] immValue,
  output logic [3:0]  aluOp,
  output logic        aluUseImm,
  output logic        memRead,
  output logic        memWrite,
  output logic [2:0]  branchKind,
  output logic        linkSel,
  output logic        illegal
);
  fieldSel_t sel;
  ctrl_t     ctrl;

  decCtrl uCtrl (
    .mainOp  (instrWord[WORD_W-1:WORD_W-OPC_W]),
    .funcCode(instrWord[OPC_W-1:0]),
    .sel     (sel),
    .ctrl    (ctrl)
  );

  decFields #(.LINK_IDX(LINK_IDX)) uFields (
    .body    (instrWord[JOFF_W-1:0]),
    .sel     (sel),
    .srcA    (srcA),
    .srcB    (srcB),
    .dstIdx  (dstIdx),
    .immValue(immValue)
  );

  assign fmtKind    = sel.fmt;
  assign linkSel    = sel.link;
  assign regWrEn    = ctrl.regWr;
  assign aluOp      = ctrl.aluOp;
  assign aluUseImm  = ctrl.useImm;
  assign memRead    = ctrl.memRd;
  assign memWrite   = ctrl.memWr;
  assign branchKind = ctrl.branch;
  assign illegal    = ctrl.illegal;

  // checks across the control / field boundary
  always_comb begin
    if (!$isunknown(instrWord)) begin
      a_r12_illegal_quiet: assert (!illegal ||
        (!regWrEn && !memRead && !memWrite && !linkSel && branchKind == 3'd0))
        else $error("illegal word left a strobe active");
      a_r9_link_dst: assert (!linkSel || (regWrEn && dstIdx == 5'(LINK_IDX)))
        else $error("link write not aimed at link register");
      a_r11_store_no_write: assert (!memWrite || (!regWrEn && !memRead))
        else $error("store also writes a register or reads memory");
      a_r1_fmt_range: assert (fmtKind != 2'd3)
        else $error("format code out of range");
      a_r2_src_fields: assert (srcA == instrWord[25:21] && srcB == instrWord[20:16])
        else $error("source index fields misplaced");
    end
  end
endmodule

// File: tb/instrDecoder_test.sv
module instrDecoder_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instrWord = '0;
  logic [1:0]  fmtKind;
  logic [4:0]  srcA, srcB, dstIdx;
  logic        regWrEn, aluUseImm, memRead, memWrite, linkSel, illegal;
  logic [31:0] immValue;
  logic [3:0]  aluOp;
  logic [2:0]  branchKind;

  int testsRun = 0;
  int testsFailed = 0;

  instrDecoder uut (
    .instrWord(instrWord), .fmtKind(fmtKind), .srcA(srcA), .srcB(srcB),
    .dstIdx(dstIdx), .regWrEn(regWrEn), .immValue(immValue), .aluOp(aluOp),
    .aluUseImm(aluUseImm), .memRead(memRead), .memWrite(memWrite),
    .branchKind(branchKind), .linkSel(linkSel), .illegal(illegal)
  );

  function automatic logic [31:0] rWord(logic [5:0] fn, logic [4:0] a, logic [4:0] b,
                                        logic [4:0] d, logic [4:0] sh);
    return {6'h00, a, b, d, sh, fn};
  endfunction

  function automatic logic [31:0] iWord(logic [5:0] op, logic [4:0] a, logic [4:0] d,
                                        logic [15:0] k);
    return {op, a, d, k};
  endfunction

  function automatic logic [31:0] jWord(logic [5:0] op, logic [25:0] off);
    return {op, off};
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(logic [31:0] w);
    @(posedge clk);
    instrWord = w;
    @(negedge clk);
  endtask

  // full expectation on one word
  task automatic expectWord(string req, logic [31:0] w, logic [1:0] f, logic [4:0] d,
      logic we, logic [31:0] im, logic [3:0] al, logic ui, logic mr, logic mw,
      logic [2:0] br, logic lk, logic il);
    drive(w);
    chk(req, "fmtKind", 32'(fmtKind), 32'(f));
    chk(req, "illegal", 32'(illegal), 32'(il));
    chk(req, "regWrEn", 32'(regWrEn), 32'(we));
    chk(req, "memRead", 32'(memRead), 32'(mr));
    chk(req, "memWrite", 32'(memWrite), 32'(mw));
    chk(req, "branchKind", 32'(branchKind), 32'(br));
    chk(req, "linkSel", 32'(linkSel), 32'(lk));
    if (!il) begin
      chk(req, "aluOp", 32'(aluOp), 32'(al));
      chk(req, "aluUseImm", 32'(aluUseImm), 32'(ui));
      chk(req, "immValue", immValue, im);
      if (we) chk(req, "dstIdx", 32'(dstIdx), 32'(d));
    end
  endtask

  task automatic testIdle();   // R12: all-zero word
    expectWord("R12", 32'h0, 2'd0, 5'd0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 1);
  endtask

  task automatic testRegOps(); // R3, R2
    logic [5:0] fns [12] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h28, 6'h29,
                             6'h2a, 6'h2c, 6'h04, 6'h06, 6'h07};
    for (int i = 0; i < 12; i++)
      expectWord("R3", rWord(fns[i], 5'd3, 5'd4, 5'd5, 5'd0), 2'd0, 5'd5, 1, 0,
                 4'(i), 0, 0, 0, 3'd0, 0, 0);
    drive(rWord(6'h20, 5'd17, 5'd9, 5'd2, 5'd0));
    chk("R2", "srcA", 32'(srcA), 32'd17);
    chk("R2", "srcB", 32'(srcB), 32'd9);
    drive(iWord(6'h2b, 5'd30, 5'd1, 16'h0));
    chk("R2", "srcA store", 32'(srcA), 32'd30);
    chk("R2", "srcB store", 32'(srcB), 32'd1);
  endtask

  task automatic testShiftFieldIgnored(); // R3: bits 10:6 have no effect
    expectWord("R3", rWord(6'h22, 5'd1, 5'd2, 5'd7, 5'h1f), 2'd0, 5'd7, 1, 0,
               4'd1, 0, 0, 0, 3'd0, 0, 0);
  endtask

  task automatic testImmAlu(); // R4, R5
    logic [5:0] ops [9] = '{6'h08, 6'h0a, 6'h14, 6'h16, 6'h17, 6'h18, 6'h19, 6'h1a, 6'h1c};
    logic [3:0] alu [9] = '{4'd0, 4'd1, 4'd9, 4'd10, 4'd11, 4'd5, 4'd6, 4'd7, 4'd8};
    for (int i = 0; i < 9; i++)
      expectWord("R4", iWord(ops[i], 5'd2, 5'd12, 16'h8001), 2'd1, 5'd12, 1,
                 32'hFFFF8001, alu[i], 1, 0, 0, 3'd0, 0, 0);
    expectWord("R5", iWord(6'h08, 5'd2, 5'd3, 16'h7FFF), 2'd1, 5'd3, 1,
               32'h00007FFF, 4'd0, 1, 0, 0, 3'd0, 0, 0);
  endtask

  task automatic testLogicImm(); // R6
    expectWord("R6", iWord(6'h0c, 5'd1, 5'd4, 16'h8001), 2'd1, 5'd4, 1,
               32'h00008001, 4'd2, 1, 0, 0, 3'd0, 0, 0);
    expectWord("R6", iWord(6'h0d, 5'd1, 5'd4, 16'hFFFF), 2'd1, 5'd4, 1,
               32'h0000FFFF, 4'd3, 1, 0, 0, 3'd0, 0, 0);
    expectWord("R6", iWord(6'h0e, 5'd1, 5'd4, 16'hA5A5), 2'd1, 5'd4, 1,
               32'h0000A5A5, 4'd4, 1, 0, 0, 3'd0, 0, 0);
  endtask

  task automatic testHigh(); // R7
    expectWord("R7", iWord(6'h0f, 5'd0, 5'd8, 16'h1234), 2'd1, 5'd8, 1,
               32'h12340000, 4'd12, 1, 0, 0, 3'd0, 0, 0);
  endtask

  task automatic testJumps(); // R8, R9
    expectWord("R8", jWord(6'h02, 26'h2000000), 2'd2, 5'd0, 0, 32'hFE000000,
               4'd0, 0, 0, 0, 3'd3, 0, 0);
    expectWord("R8", jWord(6'h02, 26'h0000010), 2'd2, 5'd0, 0, 32'h00000010,
               4'd0, 0, 0, 0, 3'd3, 0, 0);
    expectWord("R9", jWord(6'h03, 26'h3FFFFFC), 2'd2, 5'd31, 1, 32'hFFFFFFFC,
               4'd0, 0, 0, 0, 3'd3, 1, 0);
    expectWord("R9", iWord(6'h13, 5'd7, 5'd9, 16'h0), 2'd1, 5'd31, 1, 32'h0,
               4'd0, 0, 0, 0, 3'd4, 1, 0);
  endtask

  task automatic testBranches(); // R10
    expectWord("R10", iWord(6'h04, 5'd1, 5'd0, 16'hFFFC), 2'd1, 5'd0, 0, 32'hFFFFFFFC,
               4'd0, 0, 0, 0, 3'd1, 0, 0);
    expectWord("R10", iWord(6'h05, 5'd1, 5'd6, 16'h0008), 2'd1, 5'd0, 0, 32'h00000008,
               4'd0, 0, 0, 0, 3'd2, 0, 0);
    expectWord("R10", iWord(6'h12, 5'd5, 5'd6, 16'h0), 2'd1, 5'd0, 0, 32'h0,
               4'd0, 0, 0, 0, 3'd4, 0, 0);
  endtask

  task automatic testMemory(); // R11
    expectWord("R11", iWord(6'h23, 5'd2, 5'd6, 16'h8000), 2'd1, 5'd6, 1, 32'hFFFF8000,
               4'd0, 1, 1, 0, 3'd0, 0, 0);
    expectWord("R11", iWord(6'h2b, 5'd2, 5'd6, 16'h0010), 2'd1, 5'd0, 0, 32'h00000010,
               4'd0, 1, 0, 1, 3'd0, 0, 0);
  endtask

  task automatic testIllegal(); // R12
    expectWord("R12", iWord(6'h01, 5'd1, 5'd2, 16'h1), 2'd1, 5'd0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 1);
    expectWord("R12", iWord(6'h3f, 5'd1, 5'd2, 16'h1), 2'd1, 5'd0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 1);
    expectWord("R12", rWord(6'h21, 5'd1, 5'd2, 5'd3, 5'd0), 2'd0, 5'd0, 0, 0, 0, 0, 0, 0, 3'd0, 0, 1);
  endtask

  task automatic testZeroDest(); // R13
    expectWord("R13", rWord(6'h20, 5'd1, 5'd2, 5'd0, 5'd0), 2'd0, 5'd0, 1, 0,
               4'd0, 0, 0, 0, 3'd0, 0, 0);
    expectWord("R13", iWord(6'h08, 5'd1, 5'd0, 16'h0005), 2'd1, 5'd0, 1, 32'h5,
               4'd0, 1, 0, 0, 3'd0, 0, 0);
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    testIdle();
    testRegOps();
    testShiftFieldIgnored();
    testImmAlu();
    testLogicImm();
    testHigh();
    testJumps();
    testBranches();
    testMemory();
    testIllegal();
    testZeroDest();
    // R1 spot check on jump classification after other formats
    drive(jWord(6'h03, 26'h0));
    chk("R1", "fmtKind jal", 32'(fmtKind), 32'd2);
    finishRun();
  end
endmodule